// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This controller orders whole-array copies between a volatile memory and its nonvolatile shadow. A copy into the nonvolatile side is a store. A copy back into the volatile side is a recall.

A store can start in three ways:
- an external device pulls the shared active-low busy pin low;
- a power-fail comparator reports that the supply has dropped below the switch threshold;
- software issues a one-cycle pulse.

A recall can start in two ways:
- a one-cycle software pulse;
- a power-up event, latched while the supply is below the reset level.

The block keeps a dirty flag that records array writes. It uses this flag to skip pin-requested and automatic stores when no write has happened since the last nonvolatile cycle.

Toward the memory, the block sends one-cycle start strobes and a phase flag. The phase flag is erase then program during a store, and clear then load during a recall. Toward the rest of the chip, it pulls the busy pin low through an open-drain enable. It also drives two access controls: one that blocks new writes, and one that blocks all accesses. Every duration is a parameter counted in clock cycles.

Top module: `nvcopy_seq`

## Requirements
- R1: The dirty flag sets when a write-completion pulse arrives while the sequencer is idle or in the grace window. It clears when any store or recall finishes.
- R2: A store requested from the pin or from the power-fail input runs only when the dirty flag is set. A software store always runs.
- R3: A falling edge on the busy pin while idle enters a grace window that lasts GRACE_CYC cycles. During the window, writes are blocked and `acc_inhibit` stays low, so reads continue.
- R4: `busy_oe` is high in every cycle of every store, whatever started it, and is low in the cycle after the store ends.
- R5: After a pin-requested sequence, whether the store ran or was skipped, the sequencer waits in state 4 with `acc_inhibit` high until the pin is sensed high again.
- R6: On a power-fail request, the block drives the pin for the grace window. If the pin is not sensed low at the end of the window, the store is abandoned and the dirty flag is kept.
- R7: On a power-fail request with a clean dirty flag, `busy_oe` is high for exactly GRACE_CYC cycles and no store starts.
- R8: The following durations apply:
  - A store lasts STORE_CYC cycles. `xfer_phase` is low for the first ERASE_CYC cycles (erase) and high afterwards (program).
  - A software recall lasts RCL_SW_CYC cycles.
  - A power-up recall lasts RCL_PU_CYC cycles.
  - In both recalls, `xfer_phase` is low for the first CLR_CYC cycles (clear) and high afterwards (load).
- R9: A power-up recall is pending after reset and whenever `vlow_rst` is high. It starts only once `pfail` is low.
- R10: Software or pin requests that arrive while a store is running are dropped. The running store keeps its length, and nothing starts after it.
- R11: `store_go` and `recall_go` are each high for exactly one cycle, the first cycle of a store or recall.
- R12: While `pfail` is high, software store and recall pulses are ignored and `wr_block` is high.
- R13: `state_o` encodes idle=0, grace=1, storing=2, recalling=3, wait-release=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_n_in | input | 1 | Sensed level of the shared active-low busy/request pin |
| busy_oe | output | 1 | Open-drain pull-down enable for the busy pin |
| pfail | input | 1 | Power-fail comparator; high means the supply is below the switch threshold |
| vlow_rst | input | 1 | High while the supply is below the reset level |
| sw_store | input | 1 | One-cycle software store request |
| sw_recall | input | 1 | One-cycle software recall request |
| wr_done | input | 1 | One-cycle pulse when an array write completes |
| wr_block | output | 1 | New array writes must not start |
| acc_inhibit | output | 1 | All array accesses are inhibited |
| store_go | output | 1 | One-cycle store start strobe to the nonvolatile array |
| recall_go | output | 1 | One-cycle recall start strobe to the nonvolatile array |
| xfer_phase | output | 1 | 0 = erase/clear phase, 1 = program/load phase |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| GRACE_CYC | 4 |
| STORE_CYC | 12 |
| ERASE_CYC | 5 |
| RCL_SW_CYC | 6 |
| RCL_PU_CYC | 10 |
| CLR_CYC | 3 |

With these values, every store, recall and grace window finishes in tens of cycles. The bench can therefore count the exact cycles spent in each state, each phase and each pin drive, and compare them with the parameters arithmetically.

These short windows also make it cheap to sweep every request source against both settings of the dirty flag. They put within reach the corner cases that depend on timing:
- a write completing inside the grace window;
- a stuck-high pin at the end of a power-fail window;
- requests landing in the middle of a store;
- a recall that is held off until the supply recovers.

// File: rtl/nvcopy_pkg.sv
package nvcopy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GRACE   = 3'd1,
    ST_STORE   = 3'd2,
    ST_RECALL  = 3'd3,
    ST_WAITREL = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_SW    = 2'd0,
    SRC_HW    = 2'd1,
    SRC_AUTO  = 2'd2,
    SRC_PWRUP = 2'd3
  } req_src_e;

  function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvcopy_edge.sv
// Samples asynchronous level inputs once and reports a change flag per bit.
module nvcopy_edge #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s0, s1;
    always_ff @(posedge clk) begin
      if (rst) begin
        s0 <= RST_VAL[i];
        s1 <= RST_VAL[i];
      end else begin
        s0 <= din[i];
        s1 <= s0;
      end
    end
    assign lvl[i] = s0;
    assign chg[i] = s0 ^ s1;
  end

endmodule

// File: rtl/nvcopy_timer.sv
// Phase counter shared by every timed state; restarts on each state change.
module nvcopy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != {CW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/nvcopy_dirty.sv
// Write-since-last-nonvolatile-cycle flag; clearing wins over setting.
module nvcopy_dirty (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic dirty
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dirty <= 1'b0;
    end else if (set) begin
      dirty <= 1'b1;
    end
  end

endmodule

// File: rtl/nvcopy_seq.sv
module nvcopy_seq
  import nvcopy_pkg::*;
#(
  parameter int GRACE_CYC  = 50,
  parameter int STORE_CYC  = 500000,
  parameter int ERASE_CYC  = 200000,
  parameter int RCL_SW_CYC = 1000,
  parameter int RCL_PU_CYC = 27500,
  parameter int CLR_CYC    = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy_n_in,
  output logic       busy_oe,
  input  logic       pfail,
  input  logic       vlow_rst,
  input  logic       sw_store,
  input  logic       sw_recall,
  input  logic       wr_done,
  output logic       wr_block,
  output logic       acc_inhibit,
  output logic       store_go,
  output logic       recall_go,
  output logic       xfer_phase,
  output logic [2:0] state_o
);

  localparam int MAXLEN = int'(max_of2(max_of2(GRACE_CYC, STORE_CYC),
                                       max_of2(RCL_SW_CYC, RCL_PU_CYC)));
  localparam int CW = $clog2(MAXLEN + 1);

  seq_state_e state, state_n;
  req_src_e   src, src_n;
  logic [CW-1:0] cnt, last_idx;
  logic [1:0] smp_lvl, smp_chg;
  logic pin_lvl, pin_fall, pf_lvl, pf_rise;
  logic last, dirty, dirty_set, dirty_clr, pu_pend, restart;

  // bit 1: busy pin (idles high), bit 0: power-fail (idles low)
  nvcopy_edge #(.W(2), .RST_VAL(2'b10)) u_smp (
    .clk(clk), .rst(rst), .din({busy_n_in, pfail}), .lvl(smp_lvl), .chg(smp_chg)
  );

  assign pin_lvl  = smp_lvl[1];
  assign pin_fall = smp_chg[1] & ~smp_lvl[1];
  assign pf_lvl   = smp_lvl[0];
  assign pf_rise  = smp_chg[0] & smp_lvl[0];

  nvcopy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .restart(restart), .cnt(cnt)
  );

  assign dirty_set = wr_done && (state == ST_IDLE || state == ST_GRACE);
  assign dirty_clr = (state == ST_STORE || state == ST_RECALL) && last;

  nvcopy_dirty u_dirty (
    .clk(clk), .rst(rst), .set(dirty_set), .clr(dirty_clr), .dirty(dirty)
  );

  always_comb begin
    case (state)
      ST_GRACE:  last_idx = CW'(GRACE_CYC - 1);
      ST_STORE:  last_idx = CW'(STORE_CYC - 1);
      ST_RECALL: last_idx = (src == SRC_PWRUP) ? CW'(RCL_PU_CYC - 1) : CW'(RCL_SW_CYC - 1);
      default:   last_idx = '0;
    endcase
  end

  assign last = (cnt == last_idx);

  always_comb begin
    state_n = state;
    src_n   = src;
    case (state)
      ST_IDLE: begin
        if (pu_pend && !pf_lvl) begin
          state_n = ST_RECALL;
          src_n   = SRC_PWRUP;
        end else if (pf_rise) begin
          state_n = ST_GRACE;
          src_n   = SRC_AUTO;
        end else if (pin_fall) begin
          state_n = ST_GRACE;
          src_n   = SRC_HW;
        end else if (sw_store && !pf_lvl) begin
          state_n = ST_STORE;
          src_n   = SRC_SW;
        end else if (sw_recall && !pf_lvl) begin
          state_n = ST_RECALL;
          src_n   = SRC_SW;
        end
      end
      ST_GRACE: begin
        if (last) begin
          if (src == SRC_AUTO) begin
            if (pin_lvl || !dirty) state_n = ST_IDLE;
            else                   state_n = ST_STORE;
          end else begin
            state_n = dirty ? ST_STORE : ST_WAITREL;
          end
        end
      end
      ST_STORE:   if (last) state_n = (src == SRC_HW) ? ST_WAITREL : ST_IDLE;
      ST_RECALL:  if (last) state_n = ST_IDLE;
      ST_WAITREL: if (pin_lvl) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  assign restart = (state_n != state);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      src     <= SRC_SW;
      pu_pend <= 1'b1;
    end else begin
      state <= state_n;
      src   <= src_n;
      if (vlow_rst)                                          pu_pend <= 1'b1;
      else if (state_n == ST_RECALL && src_n == SRC_PWRUP)   pu_pend <= 1'b0;
    end
  end

  assign busy_oe     = (state == ST_STORE) || (state == ST_GRACE && src == SRC_AUTO);
  assign wr_block    = (state != ST_IDLE) || pf_lvl;
  assign acc_inhibit = (state == ST_STORE) || (state == ST_RECALL) || (state == ST_WAITREL);
  assign store_go    = (state == ST_STORE) && (cnt == '0);
  assign recall_go   = (state == ST_RECALL) && (cnt == '0);
  assign xfer_phase  = ((state == ST_STORE) && (cnt >= CW'(ERASE_CYC))) ||
                       ((state == ST_RECALL) && (cnt >= CW'(CLR_CYC)));
  assign state_o     = state;

  AST_PIN_LOW_IN_STORE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STORE && cnt != '0) |-> !pin_lvl); // R4
  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_STORE && $past(state) == ST_STORE) |-> !busy_oe); // R4
  AST_CLEAN_SKIP: assert property (@(posedge clk) disable iff (rst)
    (store_go && src != SRC_SW) |-> dirty); // R2
  AST_DIRTY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (($past(state) == ST_STORE || $past(state) == ST_RECALL) && state != $past(state)) |-> !dirty); // R1
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    store_go |=> !store_go); // R11
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITREL && !pin_lvl) |=> state == ST_WAITREL); // R5
  AST_STORE_LEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STORE && cnt == CW'(STORE_CYC - 1)) |=> state != ST_STORE); // R8

endmodule

// File: tb/sim_nvcopy_seq.sv
`timescale 1ns/1ps
module sim_nvcopy_seq;

  localparam int GRACE_C = 4;
  localparam int STORE_C = 12;
  localparam int ERASE_C = 5;
  localparam int RSW_C   = 6;
  localparam int RPU_C   = 10;
  localparam int CLR_C   = 3;

  localparam logic [2:0] S_IDLE = 3'd0, S_GRACE = 3'd1, S_STORE = 3'd2,
                         S_RECALL = 3'd3, S_WAIT = 3'd4;

  localparam int K_SGO = 0, K_RGO = 1, K_OE = 2, K_ST = 3, K_PH = 8,
                 K_GACC = 9, K_GBLK = 10, K_NOINH = 11;

  logic clk = 1'b0;
  logic rst, ext_low, stuck_hi, pfail, vlow, sw_store, sw_recall, wr_done;
  logic busy_oe, wr_block, acc_inhibit, store_go, recall_go, xfer_phase;
  logic [2:0] state_o;
  wire busy_n = stuck_hi ? 1'b1 : ~(busy_oe | ext_low);

  int checks = 0;
  int errors = 0;
  int cnt_now[12];
  int cnt_base[12];

  always #2.5 clk = ~clk;

  nvcopy_seq #(
    .GRACE_CYC(GRACE_C), .STORE_CYC(STORE_C), .ERASE_CYC(ERASE_C),
    .RCL_SW_CYC(RSW_C), .RCL_PU_CYC(RPU_C), .CLR_CYC(CLR_C)
  ) u0 (
    .clk(clk), .rst(rst), .busy_n_in(busy_n), .busy_oe(busy_oe), .pfail(pfail),
    .vlow_rst(vlow), .sw_store(sw_store), .sw_recall(sw_recall), .wr_done(wr_done),
    .wr_block(wr_block), .acc_inhibit(acc_inhibit), .store_go(store_go),
    .recall_go(recall_go), .xfer_phase(xfer_phase), .state_o(state_o)
  );

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      cnt_now[K_SGO] += int'(store_go);
      cnt_now[K_RGO] += int'(recall_go);
      cnt_now[K_OE]  += int'(busy_oe);
      cnt_now[K_PH]  += int'(xfer_phase);
      if (state_o <= S_WAIT) cnt_now[K_ST + int'(state_o)] += 1;
      if (state_o == S_GRACE && acc_inhibit)  cnt_now[K_GACC] += 1;
      if (state_o == S_GRACE && wr_block)     cnt_now[K_GBLK] += 1;
      if ((state_o == S_STORE || state_o == S_RECALL) && !acc_inhibit) cnt_now[K_NOINH] += 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 12; i++) cnt_base[i] = cnt_now[i];
  endtask

  function automatic int dlt(input int k);
    return cnt_now[k] - cnt_base[k];
  endfunction

  task automatic wait_state(input logic [2:0] s, input int lim, input string tag);
    int n = 0;
    while (state_o != s && n < lim) begin
      @(negedge clk);
      n++;
    end
    if (state_o != s) chk({tag, " timeout waiting for state"}, int'(state_o), int'(s));
  endtask

  task automatic pulse_wr();
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
  endtask

  task automatic pulse_sw(input bit rec);
    @(negedge clk);
    if (rec) sw_recall = 1'b1; else sw_store = 1'b1;
    @(negedge clk);
    sw_recall = 1'b0; sw_store = 1'b0;
  endtask

  task automatic hw_case(input bit wr, input bit exp_store);
    if (wr) pulse_wr();
    snap();
    @(negedge clk); ext_low = 1'b1;
    wait_state(S_WAIT, 100, "R5 hw");
    chk("R3 grace length", dlt(K_ST + 1), GRACE_C);
    chk("R3 writes blocked in grace", dlt(K_GBLK), GRACE_C);
    chk("R3 reads allowed in grace", dlt(K_GACC), 0);
    chk("R2 hw store cycles", dlt(K_ST + 2), exp_store ? STORE_C : 0);
    chk("R11 hw store strobe", dlt(K_SGO), int'(exp_store));
    chk("R4 hw pin drive", dlt(K_OE), exp_store ? STORE_C : 0);
    repeat (3) @(negedge clk);
    chk("R5 still waiting", int'(state_o), int'(S_WAIT));
    chk("R5 inhibit while waiting", int'(acc_inhibit), 1);
    ext_low = 1'b0;
    wait_state(S_IDLE, 5, "R5 release");
    chk("R5 writes open after release", int'(wr_block), 0);
  endtask

  task automatic auto_case(input bit wr, input bit stuck, input bit exp_store);
    if (wr) pulse_wr();
    stuck_hi = stuck;
    snap();
    @(negedge clk); pfail = 1'b1;
    wait_state(S_GRACE, 10, "R6 auto");
    wait_state(S_IDLE, 60, "R6 auto end");
    chk("R2 auto store cycles", dlt(K_ST + 2), exp_store ? STORE_C : 0);
    chk("R7 auto pin drive", dlt(K_OE), GRACE_C + (exp_store ? STORE_C : 0));
    chk("R11 auto store strobe", dlt(K_SGO), int'(exp_store));
    @(negedge clk); pfail = 1'b0; stuck_hi = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sw_case(input bit wr);
    if (wr) pulse_wr();
    snap();
    pulse_sw(1'b0);
    wait_state(S_STORE, 5, "R2 sw");
    wait_state(S_IDLE, 40, "R2 sw end");
    chk("R2 sw store cycles", dlt(K_ST + 2), STORE_C);
    chk("R8 program phase cycles", dlt(K_PH), STORE_C - ERASE_C);
    chk("R4 sw pin drive", dlt(K_OE), STORE_C);
    chk("R11 sw store strobe", dlt(K_SGO), 1);
    chk("R8 store inhibits access", dlt(K_NOINH), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 12; i++) begin cnt_now[i] = 0; cnt_base[i] = 0; end
    rst = 1'b1; ext_low = 1'b0; stuck_hi = 1'b0; pfail = 1'b0; vlow = 1'b0;
    sw_store = 1'b0; sw_recall = 1'b0; wr_done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 reset state idle", int'(state_o), int'(S_IDLE));
    chk("R4 no drive in reset", int'(busy_oe), 0);
    chk("R11 no strobe in reset", int'(store_go | recall_go), 0);

    snap();
    rst = 1'b0;
    wait_state(S_RECALL, 5, "R9 power-up");
    wait_state(S_IDLE, 40, "R9 power-up end");
    chk("R9 power-up recall length", dlt(K_ST + 3), RPU_C);
    chk("R11 recall strobe", dlt(K_RGO), 1);
    chk("R8 load phase cycles", dlt(K_PH), RPU_C - CLR_C);

    snap();
    pulse_sw(1'b1);
    wait_state(S_IDLE, 40, "R8 sw recall");
    chk("R8 sw recall length", dlt(K_ST + 3), RSW_C);
    chk("R8 sw recall load phase", dlt(K_PH), RSW_C - CLR_C);
    chk("R8 recall inhibits access", dlt(K_NOINH), 0);

    for (int wr = 0; wr < 2; wr++) begin
      hw_case(wr[0], wr[0]);
      auto_case(wr[0], 1'b0, wr[0]);
      sw_case(wr[0]);
    end

    // R1: a store leaves the flag clean
    sw_case(1'b1);
    hw_case(1'b0, 1'b0);
    // R1: a recall clears the flag
    pulse_wr();
    pulse_sw(1'b1);
    wait_state(S_IDLE, 40, "R1 recall");
    hw_case(1'b0, 1'b0);

    // R1/R3: a write finishing in the grace window counts
    snap();
    @(negedge clk); ext_low = 1'b1;
    wait_state(S_GRACE, 10, "R1 grace");
    pulse_wr();
    wait_state(S_WAIT, 60, "R1 grace wait");
    chk("R1 grace write makes store", dlt(K_ST + 2), STORE_C);
    ext_low = 1'b0;
    wait_state(S_IDLE, 5, "R1 grace release");

    // R6: stuck-high pin abandons, flag kept
    auto_case(1'b1, 1'b1, 1'b0);
    hw_case(1'b0, 1'b1);

    // R10: requests during a store are dropped
    snap();
    pulse_sw(1'b0);
    wait_state(S_STORE, 5, "R10 store");
    pulse_sw(1'b1);
    pulse_sw(1'b0);
    wait_state(S_IDLE, 40, "R10 end");
    repeat (5) @(negedge clk);
    chk("R10 store length kept", dlt(K_ST + 2), STORE_C);
    chk("R10 recall dropped", dlt(K_RGO), 0);
    chk("R10 second store dropped", dlt(K_SGO), 1);
    chk("R10 idle afterwards", int'(state_o), int'(S_IDLE));

    // R12 and R9: supply low
    @(negedge clk); pfail = 1'b1;
    wait_state(S_GRACE, 10, "R12 auto");
    wait_state(S_IDLE, 20, "R12 auto end");
    snap();
    pulse_sw(1'b0);
    pulse_sw(1'b1);
    repeat (4) @(negedge clk);
    chk("R12 sw store ignored", dlt(K_SGO), 0);
    chk("R12 sw recall ignored", dlt(K_RGO), 0);
    chk("R12 writes blocked", int'(wr_block), 1);
    @(negedge clk); vlow = 1'b1;
    @(negedge clk); vlow = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 recall held while supply low", int'(state_o), int'(S_IDLE));
    snap();
    pfail = 1'b0;
    wait_state(S_RECALL, 10, "R9 latched");
    wait_state(S_IDLE, 40, "R9 latched end");
    chk("R9 latched recall length", dlt(K_ST + 3), RPU_C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule